// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block sits on the host side of a four-channel, 12-bit serial analog-to-digital converter that is run with the host supplying the serial clock. A one-cycle `start` pulse opens a transaction. The controller pulls chip select low and sends an 8-bit command, most significant bit first. The command is a leading 1, then five configuration bits taken from `cfg`, then two trailing 1s. The serial clock keeps running after the command, and the controller watches the converter's strobe line. When the strobe goes from high to low, the controller captures sixteen bits on sixteen rising serial-clock edges. It keeps the first twelve as the conversion code, drops the last four, and raises chip select again.

The code comes out twice. `code` gives the raw 12-bit value. `value` gives the code widened to `OUT_W` bits: zero-extended for a unipolar range, or sign-extended as two's complement for a bipolar range. A `done` pulse marks a new result. If the strobe does not fall within `tmo_limit` serial-clock periods after the command, the transaction is abandoned and a `timeout` pulse is raised instead of `done`.

Top module: `sadc_ctrl`

## Requirements
- R1: After reset and between transactions, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_din` is 0, and `busy`, `done` and `timeout` are 0.
- R2: Each transaction starts by sending the byte {1, cfg[4:0], 1, 1} on `adc_din`, most significant bit first, over the first 8 rising edges of `adc_sclk`. `adc_din` changes only while `adc_sclk` is low, so it holds steady at every rising edge.
- R3: While `adc_cs_n` is low, `adc_sclk` runs continuously. Its period is 2*SCLK_HALF system clocks.
- R4: Reading starts only on a high-to-low change of `adc_strb` that happens after the command has been sent. A strobe that is already low when the command ends does not start a read, and the transaction then runs into the timeout.
- R5: After the strobe falls, `adc_dout` is sampled on the next 16 rising edges of `adc_sclk`. The first 12 samples, first sample as bit 11, form `code`. The last 4 samples have no effect on `code` or `value`.
- R6: On the `adc_sclk` falling edge after the 16th sample, `adc_cs_n` returns to 1 and `done` pulses for one cycle. `code` and `value` then hold until the next `done`. A completed read totals 8 + d + 16 rising edges, where d is the number of rising edges after the command up to and including the one after which the strobe fell.
- R7: When `bipolar` is 0 at `start`, `value` is `code` zero-extended to OUT_W bits. For example, 12'hFFF gives 16'h0FFF.
- R8: When `bipolar` is 1 at `start`, `value` is `code` sign-extended. 12'h7FF gives +2047 (16'h07FF), 12'h800 gives -2048 (16'hF800), and 12'h000 gives 0.
- R9: A `start` pulse while `busy` is 1 is ignored. It causes no second chip-select cycle and no second result.
- R10: If the strobe has not fallen by the tmo_limit-th falling edge of `adc_sclk` after the command, that edge ends the transaction. `adc_cs_n` returns to 1, `timeout` pulses for one cycle, and `done` does not pulse, so the transaction totals 8 + tmo_limit rising edges. `done` and `timeout` never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a conversion |
| cfg | input | 5 | Middle five command bits (channel and input mode), sampled at start |
| bipolar | input | 1 | Result range, sampled at start: 1 = two's complement, 0 = straight binary |
| tmo_limit | input | TMO_W | Serial-clock periods allowed for the strobe to fall |
| adc_strb | input | 1 | Strobe from the converter |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Serial command data to the converter |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse: a new result is on code and value |
| timeout | output | 1 | One-cycle pulse: the transaction was aborted |
| code | output | 12 | Raw 12-bit conversion code |
| value | output | OUT_W | Code widened according to the range |

## Verification
The assertions assume that `adc_strb` and `adc_dout` change in step with the system clock, and that `start` is a single-cycle pulse. On that basis, any chip-select rise must come with `done` or `timeout`, and any rise of `busy` must follow a `start`. The stimulus changes the strobe and data lines one nanosecond after a rising serial-clock edge, well away from the next system-clock edge. It always drops the strobe at least one rising edge after the command, except in the case that deliberately lowers it during the command. It also sends one `start` in the middle of a busy transaction, so the ignore path runs under the same input rules.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;
    localparam int CMD_W   = 8;
    localparam int FRAME_W = 16;
    localparam int CODE_W  = 12;
    localparam int CFG_W   = 5;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_READ
    } seq_st_e;

    // start bit, five configuration bits, two mode bits for host-clocked operation
    function automatic logic [CMD_W-1:0] make_cmd(input logic [CFG_W-1:0] cfg);
        return {1'b1, cfg, 2'b11};
    endfunction
endpackage

// File: rtl/sadc_sclk_gen.sv
`timescale 1ns/1ps
module sadc_sclk_gen #(
    parameter int SCLK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        rise  = 1'b0;
        fall  = 1'b0;
        if (!en) begin
            gen_d.cnt  = '0;
            gen_d.sclk = 1'b0;
        end else if (gen_q.cnt == CW'(SCLK_HALF - 1)) begin
            gen_d.cnt  = '0;
            gen_d.sclk = ~gen_q.sclk;
            rise       = ~gen_q.sclk;
            fall       = gen_q.sclk;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sclk = gen_q.sclk;
endmodule

// File: rtl/sadc_seq.sv
`timescale 1ns/1ps
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              bipolar,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              strb,
    input  logic              dout,
    input  logic              rise,
    input  logic              fall,
    output logic              active,
    output logic              cs_n,
    output logic              din,
    output logic              done,
    output logic              timeout,
    output logic [CODE_W-1:0] code,
    output logic              code_bip
);
    typedef struct packed {
        seq_st_e             st;
        logic                cs_n;
        logic [CNT_W-1:0]    cnt;
        logic                last;
        logic [CMD_W-1:0]    cmd_sr;
        logic [FRAME_W-1:0]  rx_sr;
        logic [TMO_W-1:0]    tmo;
        logic                bip;
        logic                strb_q;
        logic                done;
        logic                tmo_p;
        logic [CODE_W-1:0]   code;
        logic                code_bip;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_IDLE, cs_n: 1'b1, cnt: '0, last: 1'b0, cmd_sr: '0,
        rx_sr: '0, tmo: '0, bip: 1'b0, strb_q: 1'b1, done: 1'b0,
        tmo_p: 1'b0, code: '0, code_bip: 1'b0
    };

    seq_t seq_d, seq_q;
    logic strb_fell;
    logic tmo_hit;

    assign strb_fell = seq_q.strb_q & ~strb;
    assign tmo_hit   = ({1'b0, seq_q.tmo} + 1'b1) >= {1'b0, tmo_limit};

    always_comb begin
        seq_d        = seq_q;
        seq_d.done   = 1'b0;
        seq_d.tmo_p  = 1'b0;
        seq_d.strb_q = strb;
        case (seq_q.st)
            ST_IDLE: begin
                seq_d.cs_n = 1'b1;
                if (start) begin
                    seq_d.st     = ST_CMD;
                    seq_d.cs_n   = 1'b0;
                    seq_d.cnt    = '0;
                    seq_d.cmd_sr = make_cmd(cfg);
                    seq_d.bip    = bipolar;
                end
            end
            ST_CMD: begin
                if (fall) begin
                    seq_d.cmd_sr = {seq_q.cmd_sr[CMD_W-2:0], 1'b0};
                    if (seq_q.cnt == CNT_W'(CMD_W - 1)) begin
                        seq_d.st  = ST_WAIT;
                        seq_d.tmo = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (strb_fell) begin
                    seq_d.st   = ST_READ;
                    seq_d.cnt  = '0;
                    seq_d.last = 1'b0;
                end else if (fall) begin
                    if (tmo_hit) begin
                        seq_d.st    = ST_IDLE;
                        seq_d.cs_n  = 1'b1;
                        seq_d.tmo_p = 1'b1;
                    end else begin
                        seq_d.tmo = seq_q.tmo + 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (rise && !seq_q.last) begin
                    seq_d.rx_sr = {seq_q.rx_sr[FRAME_W-2:0], dout};
                    if (seq_q.cnt == CNT_W'(FRAME_W - 1)) seq_d.last = 1'b1;
                    else                                  seq_d.cnt  = seq_q.cnt + 1'b1;
                end
                if (fall && seq_q.last) begin
                    seq_d.st       = ST_IDLE;
                    seq_d.cs_n     = 1'b1;
                    seq_d.done     = 1'b1;
                    seq_d.code     = seq_q.rx_sr[FRAME_W-1 -: CODE_W];
                    seq_d.code_bip = seq_q.bip;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign active   = (seq_q.st != ST_IDLE);
    assign cs_n     = seq_q.cs_n;
    assign din      = seq_q.cmd_sr[CMD_W-1];
    assign done     = seq_q.done;
    assign timeout  = seq_q.tmo_p;
    assign code     = seq_q.code;
    assign code_bip = seq_q.code_bip;
endmodule

// File: rtl/sadc_fmt.sv
`timescale 1ns/1ps
module sadc_fmt #(
    parameter int CODE_W = 12,
    parameter int OUT_W  = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic              bip,
    output logic [OUT_W-1:0]  value
);
    generate
        if (OUT_W > CODE_W) begin : g_ext
            logic fill;
            assign fill  = bip & code[CODE_W-1];
            assign value = {{(OUT_W - CODE_W){fill}}, code};
        end else begin : g_trunc
            assign value = code[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/sadc_ctrl.sv
`timescale 1ns/1ps
module sadc_ctrl
    import sadc_pkg::*;
#(
    parameter int SCLK_HALF = 4,
    parameter int TMO_W     = 8,
    parameter int OUT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [4:0]        cfg,
    input  logic              bipolar,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              adc_strb,
    input  logic              adc_dout,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_din,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [11:0]       code,
    output logic [OUT_W-1:0]  value
);
    logic sclk_rise, sclk_fall;
    logic seq_active;
    logic code_bip;

    sadc_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (seq_active),
        .sclk  (adc_sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    sadc_seq #(.TMO_W(TMO_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg       (cfg),
        .bipolar   (bipolar),
        .tmo_limit (tmo_limit),
        .strb      (adc_strb),
        .dout      (adc_dout),
        .rise      (sclk_rise),
        .fall      (sclk_fall),
        .active    (seq_active),
        .cs_n      (adc_cs_n),
        .din       (adc_din),
        .done      (done),
        .timeout   (timeout),
        .code      (code),
        .code_bip  (code_bip)
    );

    sadc_fmt #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_fmt (
        .code  (code),
        .bip   (code_bip),
        .value (value)
    );

    assign busy = seq_active;
endmodule

// File: rtl/sadc_ctrl_chk.sv
`timescale 1ns/1ps
module sadc_ctrl_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             timeout,
    input logic             adc_cs_n,
    input logic             adc_sclk,
    input logic             adc_din,
    input logic [11:0]      code,
    input logic [OUT_W-1:0] value
);
    a_r1_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    a_r2_din_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sclk) |-> $stable(adc_din));

    a_r6_cs_release_has_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (done || timeout));

    a_r9_busy_only_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r10_outcomes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    // R7 and R8: the low bits carry the code and the upper bits are a uniform fill
    a_r7_value_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (value[11:0] == code));

    a_r8_value_fill_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((value[OUT_W-1:12] == '0) || (value[OUT_W-1:12] == '1 && code[11])));
endmodule

bind sadc_ctrl sadc_ctrl_chk #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .adc_cs_n (adc_cs_n),
    .adc_sclk (adc_sclk),
    .adc_din  (adc_din),
    .code     (code),
    .value    (value)
);

// File: tb/sim_sadc_ctrl.sv
`timescale 1ns/1ps
module sim_sadc_ctrl;
    localparam int HALF  = 2;
    localparam int TMO_W = 8;
    localparam int OUT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4:0] cfg = '0;
    logic bipolar = 1'b0;
    logic [TMO_W-1:0] tmo_limit = 8'd20;
    logic adc_strb = 1'b1;
    logic adc_dout = 1'b0;
    logic adc_cs_n, adc_sclk, adc_din, busy, done, timeout;
    logic [11:0] code;
    logic [OUT_W-1:0] value;

    always #10 clk = ~clk;

    sadc_ctrl #(.SCLK_HALF(HALF), .TMO_W(TMO_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .bipolar(bipolar),
        .tmo_limit(tmo_limit), .adc_strb(adc_strb), .adc_dout(adc_dout),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
        .busy(busy), .done(done), .timeout(timeout), .code(code), .value(value)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int rise_cnt = 0;
    int cs_falls = 0;

    typedef struct {
        bit          is_tmo;
        logic [11:0] code;
        logic [15:0] val;
        int          rises;
        string       req;
    } exp_t;

    exp_t sb[$];

    always @(negedge adc_cs_n or posedge adc_sclk) begin
        if (adc_sclk) rise_cnt = rise_cnt + 1;
        else          rise_cnt = 0;
    end

    always @(negedge adc_cs_n) cs_falls = cs_falls + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the expected outcome whenever the design reports one
    always @(negedge clk) begin
        if (rst_n && (done || timeout)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected outcome", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(timeout == e.is_tmo, e.req, "timeout flag", timeout, e.is_tmo);
                chk(done == !e.is_tmo, e.req, "done flag", done, !e.is_tmo);
                chk(adc_cs_n == 1'b1, "R6", "cs_n at outcome", adc_cs_n, 1);
                chk(rise_cnt == e.rises, e.req, "sclk rises", rise_cnt, e.rises);
                if (!e.is_tmo) begin
                    chk(code == e.code, "R5", "code", code, e.code);
                    chk(value == e.val, e.req, "value", value, e.val);
                end
            end
        end
    end

    task automatic pulse_start(input logic [4:0] c, input logic b);
        @(negedge clk);
        cfg = c; bipolar = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic grab_cmd(input logic [4:0] c);
        logic [7:0] cap = '0;
        for (int i = 0; i < 8; i++) begin
            @(posedge adc_sclk);
            #1 cap = {cap[6:0], adc_din};
        end
        chk(cap == {1'b1, c, 2'b11}, "R2", "command byte", cap, {1'b1, c, 2'b11});
    endtask

    // driver: one full conversion with the strobe dropped after rise 8+d
    task automatic conv(input logic [4:0] c, input logic b, input logic [11:0] cd,
                        input logic [3:0] junk, input int d, input string req);
        exp_t e;
        logic [15:0] frame;
        e.is_tmo = 1'b0;
        e.code   = cd;
        e.val    = b ? {{4{cd[11]}}, cd} : {4'h0, cd};
        e.rises  = 8 + d + 16;
        e.req    = req;
        sb.push_back(e);
        frame = {cd, junk};
        pulse_start(c, b);
        grab_cmd(c);
        repeat (d) @(posedge adc_sclk);
        #1 adc_strb = 1'b0;
        adc_dout = frame[15];
        for (int i = 14; i >= 0; i--) begin
            @(posedge adc_sclk);
            #1 adc_dout = frame[i];
        end
        @(posedge adc_sclk);
        wait (!busy);
        @(negedge clk);
        adc_strb = 1'b1;
        adc_dout = 1'b0;
        @(negedge clk);
        chk(adc_din == 1'b0 && adc_sclk == 1'b0 && adc_cs_n == 1'b1, "R1",
            "idle lines after read", {adc_cs_n, adc_sclk, adc_din}, 3'b100);
    endtask

    task automatic tmo_run(input logic [TMO_W-1:0] lim, input bit early);
        exp_t e;
        e.is_tmo = 1'b1;
        e.code   = '0;
        e.val    = '0;
        e.rises  = 8 + int'(lim);
        e.req    = early ? "R4" : "R10";
        sb.push_back(e);
        tmo_limit = lim;
        pulse_start(5'b01010, 1'b0);
        if (early) begin
            repeat (3) @(posedge adc_sclk);
            #1 adc_strb = 1'b0;
        end
        wait (!busy);
        @(negedge clk);
        adc_strb = 1'b1;
        repeat (4) @(negedge clk);
        tmo_limit = 8'd20;
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        time t0;
        int falls0;
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1", "cs_n in reset", adc_cs_n, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1", "cs_n after reset", adc_cs_n, 1);
        chk(adc_sclk == 1'b0, "R1", "sclk after reset", adc_sclk, 0);
        chk(adc_din == 1'b0, "R1", "din after reset", adc_din, 0);
        chk(busy == 1'b0 && done == 1'b0 && timeout == 1'b0, "R1", "flags after reset",
            {busy, done, timeout}, 0);

        fork
            conv(5'b10110, 1'b0, 12'hA5C, 4'b1111, 1, "R7");
            begin
                @(posedge adc_sclk);
                t0 = $time;
                @(posedge adc_sclk);
                chk(($time - t0) == 2 * HALF * 20, "R3", "sclk period ns",
                    $time - t0, 2 * HALF * 20);
            end
        join

        conv(5'b00000, 1'b0, 12'h000, 4'b1111, 3, "R7");
        conv(5'b11111, 1'b0, 12'hFFF, 4'b0000, 2, "R7");
        conv(5'b00101, 1'b1, 12'h7FF, 4'b0000, 1, "R8");
        conv(5'b11000, 1'b1, 12'h800, 4'b1111, 5, "R8");
        conv(5'b01001, 1'b1, 12'h000, 4'b1111, 2, "R8");
        conv(5'b10011, 1'b1, 12'hFFF, 4'b1010, 4, "R8");

        falls0 = cs_falls;
        fork
            conv(5'b01110, 1'b0, 12'h3C1, 4'b0101, 2, "R9");
            begin
                repeat (20) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (40) @(negedge clk);
        chk(cs_falls == falls0 + 1, "R9", "chip-select cycles", cs_falls, falls0 + 1);
        chk(busy == 1'b0 && adc_cs_n == 1'b1, "R9", "idle after ignored start",
            {busy, adc_cs_n}, 2'b01);

        tmo_run(8'd4, 1'b0);
        chk(adc_cs_n == 1'b1, "R10", "cs_n after abort", adc_cs_n, 1);
        tmo_run(8'd6, 1'b1);

        conv(5'b00011, 1'b0, 12'h123, 4'b1111, 1, "R6");
        chk(code == 12'h123, "R6", "code held", code, 12'h123);

        repeat (10) @(negedge clk);
        chk(sb.size() == 0, "R6", "outstanding outcomes", sb.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule